// File: doc/BRIEF.md
# Memory-Mapped 64-Line Interrupt Controller

This block collects 64 interrupt lines from peripherals and presents them to a processor as one request line. Each line passes through a two-flop synchronizer. A rising edge on a synchronized line sets a sticky capture flag, so a short pulse is not lost. Software enables or disables each line with its own enable bit, which allows level and pulse sources to share the same inputs. A line counts as pending when it is enabled and either its synchronized level is high or its capture flag is set. A master enable bit gates the processor request.

Software reaches the block over a 32-bit APB-style bus. Read data is registered during the setup phase and is valid in the access phase. A write takes effect at the clock edge that ends the access phase. The lines are split into two 32-bit halves. A 64-byte routing table holds one byte per source, and the controller stores this table but does not interpret it.

Top module: `irq_hub64`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq_o` is 0.
- R2: The enable word for sources 0-31 is at 0x10 and the enable word for sources 32-63 is at 0x28. Bit i of each word enables the i-th source of its half. Both words are read/write.
- R3: The pending word for the low half is at 0x14 and the pending word for the high half is at 0x2C. Bit i of a pending word is 1 exactly when that source is enabled and either its synchronized line is high or its capture flag is set.
- R4: A rising edge on a synchronized line sets that source's capture flag. The low-half flags are at 0x08 and the high-half flags are at 0x20. A set flag stays 1 after the line falls.
- R5: A write to a flag word clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R6: A rising edge that lands on the same clock edge as a clearing write to the flag word leaves the flag set.
- R7: The control word is at 0x00. Bit 31 is the master enable, and all other control bits read 0. `irq_o` is a register that takes, one cycle later, the OR of all 64 pending bits ANDed with the master enable. `irq_o` is 0 whenever the master enable is 0.
- R8: The pending words are read-only. A write to either pending word changes neither the pending words nor any other register.
- R9: The routing table spans 16 read/write words from 0x40 to 0x7C. Byte k of the word at 0x40+4m belongs to source 4m+k.
- R10: Reads of any other address, including misaligned ones, return 0. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Interrupt lines, asynchronous to clk |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| irq_o | output | 1 | Processor interrupt request |

## Verification
The case that needs care is a flag being set and cleared on the same edge. A source's synchronized edge and a software write that clears its flag word can fall on the same clock edge. The bench raises a line and then starts a clearing write one cycle later. This places the write's commit edge on the same edge at which the edge detector sets the flag. The flag read back afterwards must show the new capture, while other flag bits must show the clear.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_FLAG_LO = 8'h08;
  localparam logic [7:0] OFS_EN_LO   = 8'h10;
  localparam logic [7:0] OFS_PEND_LO = 8'h14;
  localparam logic [7:0] OFS_FLAG_HI = 8'h20;
  localparam logic [7:0] OFS_EN_HI   = 8'h28;
  localparam logic [7:0] OFS_PEND_HI = 8'h2C;
  localparam logic [7:0] OFS_MAP     = 8'h40;
  localparam int unsigned MAP_BYTES  = 64;

  // Per-half offsets: index 0 = low half, 1 = high half
  function automatic logic [7:0] flag_ofs(input int unsigned w);
    return (w == 0) ? OFS_FLAG_LO : OFS_FLAG_HI;
  endfunction

  function automatic logic [7:0] en_ofs(input int unsigned w);
    return (w == 0) ? OFS_EN_LO : OFS_EN_HI;
  endfunction

  function automatic logic [7:0] pend_ofs(input int unsigned w);
    return (w == 0) ? OFS_PEND_LO : OFS_PEND_HI;
  endfunction

  function automatic logic is_map_addr(input logic [7:0] a);
    return (a >= OFS_MAP) && (a < OFS_MAP + 8'(MAP_BYTES)) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic addr_is_mapped(input logic [7:0] a);
    case (a)
      OFS_CTRL, OFS_FLAG_LO, OFS_EN_LO, OFS_PEND_LO,
      OFS_FLAG_HI, OFS_EN_HI, OFS_PEND_HI: return 1'b1;
      default: return is_map_addr(a);
    endcase
  endfunction

endpackage

// File: rtl/irq_hub_capture.sv
module irq_hub_capture #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] line_in,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] clr_data,
  output logic [WIDTH-1:0] line_sync,
  output logic [WIDTH-1:0] flag_q
);

  logic [WIDTH-1:0] stg [STAGES];
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise;
  logic [WIDTH-1:0] kept;

  assign line_sync = stg[STAGES-1];
  assign rise      = stg[STAGES-1] & ~prev_q;
  assign kept      = clr_we ? (flag_q & clr_data) : flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      stg[0] <= line_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev_q <= stg[STAGES-1];
      flag_q <= kept | rise;   // new capture wins over a clear
    end
  end

endmodule

// File: rtl/irq_hub_chanmap.sv
module irq_hub_chanmap #(
  parameter int unsigned WORDS = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/irq_hub64.sv
module irq_hub64
  import irq_hub_pkg::*;
#(
  parameter int unsigned N_SRC       = 64,
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  output logic             irq_o
);

  localparam int unsigned N_WORDS   = N_SRC / DW;
  localparam int unsigned MAP_WORDS = N_SRC / 4;
  localparam int unsigned MAP_IW    = $clog2(MAP_WORDS);
  localparam int unsigned EN_BIT    = DW - 1;

  logic wr_acc, rd_setup, map_hit;
  logic ctrl_en;
  logic [N_WORDS-1:0][DW-1:0] en_q;
  logic [N_WORDS-1:0][DW-1:0] sync_w;
  logic [N_WORDS-1:0][DW-1:0] flag_w;
  logic [N_WORDS-1:0][DW-1:0] pend_w;
  logic pend_any;
  logic [DW-1:0] map_rdata;
  logic [DW-1:0] rd_val;

  assign wr_acc   = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;
  assign map_hit  = is_map_addr(paddr);

  for (genvar w = 0; w < N_WORDS; w++) begin : g_half
    irq_hub_capture #(
      .WIDTH (DW),
      .STAGES(SYNC_STAGES)
    ) u_cap (
      .clk      (clk),
      .rst      (rst),
      .line_in  (src_i[w*DW +: DW]),
      .clr_we   (wr_acc && (paddr == AW'(flag_ofs(w)))),
      .clr_data (pwdata),
      .line_sync(sync_w[w]),
      .flag_q   (flag_w[w])
    );
    assign pend_w[w] = en_q[w] & (sync_w[w] | flag_w[w]);
  end

  assign pend_any = |pend_w;

  irq_hub_chanmap #(
    .WORDS(MAP_WORDS),
    .DW   (DW)
  ) u_map (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_acc && map_hit),
    .idx  (paddr[MAP_IW+1:2]),
    .wdata(pwdata),
    .rdata(map_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      en_q    <= '0;
    end else if (wr_acc) begin
      if (paddr == AW'(OFS_CTRL)) ctrl_en <= pwdata[EN_BIT];
      for (int w = 0; w < N_WORDS; w++)
        if (paddr == AW'(en_ofs(w))) en_q[w] <= pwdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (paddr == AW'(OFS_CTRL)) rd_val[EN_BIT] = ctrl_en;
    for (int w = 0; w < N_WORDS; w++) begin
      if (paddr == AW'(flag_ofs(w))) rd_val = flag_w[w];
      if (paddr == AW'(en_ofs(w)))   rd_val = en_q[w];
      if (paddr == AW'(pend_ofs(w))) rd_val = pend_w[w];
    end
    if (map_hit) rd_val = map_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prdata <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (rd_setup) prdata <= rd_val;
      irq_o <= ctrl_en & pend_any;
    end
  end

endmodule

// File: rtl/irq_hub64_chk.sv
module irq_hub64_chk
  import irq_hub_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [DW-1:0] prdata,
  input logic          irq_o,
  input logic          ctrl_en,
  input logic          pend_any,
  input logic [DW-1:0] flag_lo
);

  logic flag_wr_lo;
  assign flag_wr_lo = psel && penable && pwrite && (paddr == AW'(OFS_FLAG_LO));

  // R4: without a write to the low flag word, no set flag may drop
  a_r4_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !flag_wr_lo |=> ((~flag_lo & $past(flag_lo)) == '0));

  // R7: master enable low forces the request low on the next cycle
  a_r7_gate_off: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !irq_o);

  // R7: enabled and something pending raises the request next cycle
  a_r7_raise: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && pend_any) |=> irq_o);

  // R10: a read setup to an unmapped address yields zero data
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable && !pwrite && !addr_is_mapped(8'(paddr))) |=> (prdata == '0));

endmodule

bind irq_hub64 irq_hub64_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .prdata  (prdata),
  .irq_o   (irq_o),
  .ctrl_en (ctrl_en),
  .pend_any(pend_any),
  .flag_lo (flag_w[0])
);

// File: tb/irq_hub64_test.sv
`timescale 1ns/1ps
module irq_hub64_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_i = '0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  event        rd_go;

  always #2 clk = ~clk;

  irq_hub64 uut (
    .clk(clk), .rst(rst), .src_i(src_i),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares in the access phase
  always @(rd_go) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    check(t, prdata, e);
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 -> rd_go;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check("R1 irq_o", {31'd0, irq_o}, 32'd0);
    bus_read(8'h00, 32'h0, "R1 ctrl");
    bus_read(8'h10, 32'h0, "R1 en lo");
    bus_read(8'h28, 32'h0, "R1 en hi");
    bus_read(8'h14, 32'h0, "R1 pend lo");
    bus_read(8'h08, 32'h0, "R1 flag lo");
    bus_read(8'h5C, 32'h0, "R1 map");

    // R2 enables
    bus_write(8'h10, 32'h0000_00F0);
    bus_write(8'h28, 32'h8000_0001);
    bus_read(8'h10, 32'h0000_00F0, "R2 en lo");
    bus_read(8'h28, 32'h8000_0001, "R2 en hi");

    // R3 level sources, R4 capture, R7 gated while master off
    @(negedge clk);
    src_i[4] = 1'b1; src_i[2] = 1'b1; src_i[63] = 1'b1;
    idle(5);
    bus_read(8'h14, 32'h0000_0010, "R3 pend lo level");
    bus_read(8'h2C, 32'h8000_0000, "R3 pend hi level");
    bus_read(8'h08, 32'h0000_0014, "R4 flag lo captured");
    check("R7 irq off while master disabled", {31'd0, irq_o}, 32'd0);

    // R7 master enable
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, 32'h8000_0000, "R7 ctrl readback");
    idle(2);
    check("R7 irq raised", {31'd0, irq_o}, 32'd1);

    // R4 flags hold after line falls
    @(negedge clk);
    src_i[4] = 1'b0; src_i[2] = 1'b0; src_i[63] = 1'b0;
    idle(5);
    bus_read(8'h14, 32'h0000_0010, "R4 pend lo from flag");
    bus_read(8'h20, 32'h8000_0000, "R4 flag hi held");

    // R5 clear semantics
    bus_write(8'h08, 32'hFFFF_FFEF);
    bus_read(8'h08, 32'h0000_0004, "R5 flag lo partial clear");
    bus_read(8'h14, 32'h0000_0000, "R5 pend lo cleared");
    bus_write(8'h20, 32'h0000_0000);
    bus_read(8'h2C, 32'h0000_0000, "R5 pend hi cleared");
    idle(2);
    check("R7 irq drops when nothing pending", {31'd0, irq_o}, 32'd0);

    // R8 pending is read-only
    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_read(8'h14, 32'h0000_0000, "R8 pend lo unchanged");
    bus_read(8'h10, 32'h0000_00F0, "R8 en lo unchanged");

    // R6 edge on the same edge as a clearing write
    @(negedge clk);
    src_i[5] = 1'b1;
    bus_write(8'h08, 32'h0000_0000);
    bus_read(8'h08, 32'h0000_0020, "R6 capture beats clear");
    idle(2);
    check("R7 irq from captured flag", {31'd0, irq_o}, 32'd1);

    // R9 routing table
    bus_write(8'h40, 32'h0302_0100);
    bus_write(8'h7C, 32'hDEAD_BEEF);
    bus_read(8'h40, 32'h0302_0100, "R9 map word 0");
    bus_read(8'h7C, 32'hDEAD_BEEF, "R9 map word 15");
    bus_read(8'h44, 32'h0000_0000, "R9 map word 1 untouched");

    // R10 unmapped addresses
    bus_write(8'h30, 32'hFFFF_FFFF);
    bus_write(8'h80, 32'hFFFF_FFFF);
    bus_write(8'h41, 32'hFFFF_FFFF);
    bus_read(8'h30, 32'h0, "R10 read 0x30");
    bus_read(8'h04, 32'h0, "R10 read 0x04");
    bus_read(8'h80, 32'h0, "R10 read 0x80");
    bus_read(8'h41, 32'h0, "R10 misaligned read");
    bus_read(8'h40, 32'h0302_0100, "R10 map word 0 intact");
    bus_read(8'h10, 32'h0000_00F0, "R10 en lo intact");

    // R7 master disable with a source still pending
    bus_write(8'h00, 32'h0000_0000);
    idle(2);
    check("R7 irq gated off", {31'd0, irq_o}, 32'd0);
    bus_read(8'h14, 32'h0000_0020, "R3 pend visible while gated");

    idle(2);
    summary();
    $finish;
  end

endmodule